// File: doc/BRIEF.md
# Serial Flash Read and Wake Engine

This block is the host side of a four-wire serial link to a flash device. A request on the command port starts one framed transfer. Chip select goes low, the block sends an opcode and any address or dummy bytes, and then clocks in data bytes. Those bytes leave through a valid/ready byte stream. Four operations exist: a plain read, a fast read, which inserts one dummy byte after the address, a power-down request, and a wake request. The wake request can also fetch the one-byte device signature. The clock runs in mode 0: it idles low, the block samples MISO on the rising edge, and MOSI changes after the falling edge. Bits travel most significant first.

The output stream follows these back-pressure rules. A byte is delivered in the cycle where `out_valid` and `out_ready` are both high. While a byte waits, it and `out_valid` stay unchanged, the serial clock stays parked low, and chip select stays asserted. The next byte is clocked only after the waiting byte has been taken. The read address advances inside the device and wraps from its top address to zero, so one request may cross the end of the array. After a wake request, the block counts out the device's recovery time before it accepts another command. The block keeps track of whether it has put the device to sleep. While the device sleeps, the block accepts read and power-down requests but drops them without any activity on the pins.

Top module: `sflash_read_engine`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `sck` is 0, `out_valid` is 0 and `busy` is 0.
- R2: A plain read (`cmd_op`=0) sends 0x03 and then the 24-bit `cmd_addr`, high byte first. It then returns `cmd_len` bytes in address order on the stream. Every byte is MSB first on both MOSI and MISO.
- R3: A fast read (`cmd_op`=1) sends 0x0B, the address, and one dummy byte before the first data byte is clocked in.
- R4: The SCK high and low phases each last `DIV_NORM` clock cycles during a plain read, and `DIV_FAST` cycles during any other operation.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` holds, `sck` does not toggle and `cs_n` stays low.
- R6: A frame carries exactly 8 × (header bytes + returned bytes) SCK rising edges, and `cs_n` rises after the last requested byte has been taken. SCK is low whenever `cs_n` is high.
- R7: A read that starts near the top of the device array keeps streaming across the wrap to address 0 without interruption.
- R8: A power-down request (`cmd_op`=2) sends only 0xB9. After that, read and power-down requests are accepted but dropped: `cs_n` stays high, no byte is produced, and `busy` stays low.
- R9: A wake request with `cmd_sig`=0 (`cmd_op`=3) sends only 0xAB. `busy` then stays high for exactly `WAKE_PLAIN` cycles after `cs_n` rises.
- R10: A wake request with `cmd_sig`=1 sends 0xAB and three dummy bytes, and returns one signature byte on the stream. `busy` then stays high for exactly `WAKE_SIG` cycles after `cs_n` rises.
- R11: A wake request clears the sleeping condition, so a later read runs normally.
- R12: `cmd_ready` is the inverse of `busy`. `busy` is high throughout every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 plain read, 1 fast read, 2 power-down, 3 wake |
| cmd_sig | input | 1 | With a wake, also read the signature byte |
| cmd_addr | input | 24 | Start address for reads |
| cmd_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Frame in progress or wake delay running |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Stream consumer accepts the byte |
| out_data | output | 8 | Stream byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench's device model serves a computed pattern and wraps its address at the top of a 20-bit array. A read that starts two bytes below the top therefore shows whether the engine keeps clocking across the wrap; a design that stopped or restarted would deliver fewer or repeated bytes. Random back-pressure on the stream checks that no byte is lost or duplicated and that the bit count of each frame is exact. An engine that clocked ahead during a stall would show an extra or missing byte. The wake delays are counted cycle by cycle from the rise of chip select. An off-by-one in either delay, or a mix-up between the two, shows up as a wrong count. A read issued to a sleeping device has to leave the pins untouched. A design that sent it anyway would show a frame in the model's log.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_FAST  = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } sfr_op_e;

  localparam logic [7:0] CODE_READ  = 8'h03;
  localparam logic [7:0] CODE_FAST  = 8'h0B;
  localparam logic [7:0] CODE_SLEEP = 8'hB9;
  localparam logic [7:0] CODE_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR_GO, S_HDR_WAIT, S_RX_GO, S_RX_WAIT, S_HOLD, S_FIN
  } sfr_state_e;
endpackage

// File: rtl/sfr_hdr.sv
module sfr_hdr
  import sfr_pkg::*;
(
  input  sfr_op_e                op,
  input  logic                   sig,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [2:0]             idx,
  output logic [7:0]             tx_byte,
  output logic [2:0]             hdr_len
);
  always_comb begin
    unique case (op)
      OP_READ:  hdr_len = 3'd4;
      OP_FAST:  hdr_len = 3'd5;
      OP_SLEEP: hdr_len = 3'd1;
      default:  hdr_len = sig ? 3'd4 : 3'd1;
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    if (idx == 3'd0) begin
      unique case (op)
        OP_READ:  tx_byte = CODE_READ;
        OP_FAST:  tx_byte = CODE_FAST;
        OP_SLEEP: tx_byte = CODE_SLEEP;
        default:  tx_byte = CODE_WAKE;
      endcase
    end else if (op == OP_READ || op == OP_FAST) begin
      unique case (idx)
        3'd1:    tx_byte = addr[23:16];
        3'd2:    tx_byte = addr[15:8];
        3'd3:    tx_byte = addr[7:0];
        default: tx_byte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int DIV_NORM = 2,
  parameter int DIV_FAST = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fast,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done
);
  localparam int DMAX = (DIV_NORM > DIV_FAST) ? DIV_NORM : DIV_FAST;
  localparam int CW   = $clog2(DMAX + 1);

  logic          active;
  logic          fast_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  assign lim = fast_q ? CW'(DIV_FAST - 1) : CW'(DIV_NORM - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fast_q <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        fast_q <= fast;
        sh     <= tx;
        mosi   <= tx[7];
        bitn   <= '0;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == lim) begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
              mosi   <= 1'b0;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfr_wake_timer.sv
module sfr_wake_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= val;
    else if (cnt != 0) cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sflash_read_engine.sv
module sflash_read_engine
  import sfr_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int DIV_NORM   = 2,
  parameter int DIV_FAST   = 1,
  parameter int WAKE_PLAIN = 150,
  parameter int WAKE_SIG   = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_sig,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int WMAX = (WAKE_PLAIN > WAKE_SIG) ? WAKE_PLAIN : WAKE_SIG;
  localparam int WCW  = $clog2(WMAX + 1);

  sfr_state_e        state;
  sfr_op_e           op_q;
  logic              sig_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rx_left;
  logic [2:0]        idx;
  logic              asleep;

  logic [7:0]        hdr_byte;
  logic [2:0]        hdr_len;
  logic              sh_start;
  logic [7:0]        sh_tx;
  logic [7:0]        sh_rx;
  logic              sh_done;
  logic              wake_load;
  logic [WCW-1:0]    wake_val;
  logic              wake_busy;
  logic              accept;
  sfr_op_e           new_op;

  sfr_hdr u_hdr (
    .op      (op_q),
    .sig     (sig_q),
    .addr    (addr_q),
    .idx     (idx),
    .tx_byte (hdr_byte),
    .hdr_len (hdr_len)
  );

  assign sh_start = (state == S_HDR_GO) || (state == S_RX_GO);
  assign sh_tx    = (state == S_RX_GO) ? 8'h00 : hdr_byte;

  sfr_shifter #(.DIV_NORM(DIV_NORM), .DIV_FAST(DIV_FAST)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .fast  (op_q != OP_READ),
    .tx    (sh_tx),
    .miso  (miso),
    .sck   (sck),
    .mosi  (mosi),
    .rx    (sh_rx),
    .done  (sh_done)
  );

  assign wake_load = (state == S_FIN) && (op_q == OP_WAKE);
  assign wake_val  = sig_q ? WCW'(WAKE_SIG) : WCW'(WAKE_PLAIN);

  sfr_wake_timer #(.CW(WCW)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wake_load),
    .val   (wake_val),
    .busy  (wake_busy)
  );

  assign busy      = (state != S_IDLE) || wake_busy;
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign new_op    = sfr_op_e'(cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_READ;
      sig_q     <= 1'b0;
      addr_q    <= '0;
      rx_left   <= '0;
      idx       <= '0;
      asleep    <= 1'b0;
      cs_n      <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= new_op;
            sig_q  <= cmd_sig;
            addr_q <= cmd_addr;
            idx    <= '0;
            if (new_op == OP_READ || new_op == OP_FAST) rx_left <= cmd_len;
            else if (new_op == OP_WAKE && cmd_sig)      rx_left <= LEN_W'(1);
            else                                        rx_left <= '0;
            if (!asleep || new_op == OP_WAKE) begin
              cs_n  <= 1'b0;
              state <= S_HDR_GO;
            end
          end
        end
        S_HDR_GO: state <= S_HDR_WAIT;
        S_HDR_WAIT: begin
          if (sh_done) begin
            if (idx == hdr_len - 3'd1) begin
              state <= (rx_left != '0) ? S_RX_GO : S_FIN;
            end else begin
              idx   <= idx + 3'd1;
              state <= S_HDR_GO;
            end
          end
        end
        S_RX_GO: state <= S_RX_WAIT;
        S_RX_WAIT: begin
          if (sh_done) begin
            out_data  <= sh_rx;
            out_valid <= 1'b1;
            rx_left   <= rx_left - LEN_W'(1);
            state     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= (rx_left == '0) ? S_FIN : S_RX_GO;
          end
        end
        default: begin
          cs_n  <= 1'b1;
          state <= S_IDLE;
          if (op_q == OP_SLEEP) asleep <= 1'b1;
          if (op_q == OP_WAKE)  asleep <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sflash_read_engine_chk.sv
module sflash_read_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       sck,
  input logic       cs_n
);
  // R5: a waiting byte freezes the serial clock and keeps the frame open
  a_r5_stall_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(sck) && !cs_n));

  // R5: a waiting byte is neither dropped nor changed
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: no clock outside a frame
  a_r6_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R12: a frame in progress always reports busy and refuses commands
  a_r12_busy_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (busy && !cmd_ready));

  // R2: stream bytes only appear inside a frame
  a_r2_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cs_n);
endmodule

bind sflash_read_engine sflash_read_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .sck       (sck),
  .cs_n      (cs_n)
);

// File: tb/tb_sflash_read_engine.sv
module tb_sflash_read_engine;
  localparam int WP = 150;
  localparam int WS = 90;
  localparam int DN = 2;
  localparam int DF = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_sig = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        busy;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        sck, mosi, cs_n;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  sflash_read_engine #(.LEN_W(16), .DIV_NORM(DN), .DIV_FAST(DF),
                       .WAKE_PLAIN(WP), .WAKE_SIG(WS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sig(cmd_sig), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  // ---------------- device model ----------------
  logic [7:0] hdr [5];
  logic [7:0] last_hdr [5];
  int  nbits = 0;
  int  frames = 0;
  int  last_bits = 0;
  bit  in_frame = 0;
  bit  m_asleep = 0;

  initial for (int i = 0; i < 5; i++) begin hdr[i] = '0; last_hdr[i] = '0; end

  always @(negedge cs_n) begin
    nbits = 0;
    in_frame = 1;
    for (int i = 0; i < 5; i++) hdr[i] = '0;
  end

  always @(posedge sck) if (!cs_n) begin
    if (nbits < 40) hdr[nbits / 8][7 - (nbits % 8)] = mosi;
    nbits++;
  end

  always @(negedge sck) if (!cs_n) begin
    int st;
    logic [19:0] a;
    logic [7:0] b;
    st = 1 << 20;
    if (hdr[0] == 8'h03 && !m_asleep) st = 32;
    if (hdr[0] == 8'h0B && !m_asleep) st = 40;
    if (hdr[0] == 8'hAB) st = 32;
    if (nbits >= st) begin
      a = {hdr[1][3:0], hdr[2], hdr[3]} + 20'((nbits - st) / 8);
      b = (hdr[0] == 8'hAB) ? 8'h13 : memf(a);
      miso <= b[7 - ((nbits - st) % 8)];
    end
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    frames++;
    last_bits = nbits;
    for (int i = 0; i < 5; i++) last_hdr[i] = hdr[i];
    if (hdr[0] == 8'hB9 && nbits == 8) m_asleep = 1;
    if (hdr[0] == 8'hAB) m_asleep = 0;
  end

  // SCK high width in system clocks
  int hw = 0;
  int last_hw = 0;
  always @(posedge clk) begin
    if (sck) hw++;
    else if (hw != 0) begin last_hw = hw; hw = 0; end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] got [64];

  task automatic do_cmd(logic [1:0] op, logic sig, logic [23:0] a, int len);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sig = sig; cmd_addr = a; cmd_len = 16'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic collect(int len, int stall);
    int n = 0;
    while (n < len) begin
      @(negedge clk);
      out_ready = (($urandom % 100) >= stall);
      if (out_valid && out_ready) begin got[n] = out_data; n++; end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cs_n && !busy)) @(negedge clk);
  endtask

  task automatic run_read(string tag, bit fast, logic [23:0] a, int len, int stall);
    int base = frames;
    int hl = fast ? 5 : 4;
    do_cmd(fast ? 2'd1 : 2'd0, 1'b0, a, len);
    collect(len, stall);
    wait_idle();
    chk({tag, " frame count"}, frames - base, 1);
    chk({tag, " R6 bit count"}, last_bits, 8 * (hl + len));
    chk({tag, fast ? " R3 opcode" : " R2 opcode"}, last_hdr[0], fast ? 8'h0B : 8'h03);
    chk({tag, " R2 address"}, {last_hdr[1], last_hdr[2], last_hdr[3]}, a);
    chk({tag, " R4 sck half width"}, last_hw, fast ? DF : DN);
    for (int k = 0; k < len; k++)
      chk({tag, " R2 data byte"}, got[k], memf(a[19:0] + 20'(k)));
  endtask

  task automatic run_wake(bit sig, int expw);
    int c = 0;
    int bad = 0;
    do_cmd(2'd3, sig, 24'h0, 0);
    if (sig) begin
      collect(1, 30);
      chk("R10 signature byte", got[0], 8'h13);
    end
    while (!cs_n) @(negedge clk);
    while (busy) begin
      if (cmd_ready) bad++;
      c++;
      @(negedge clk);
    end
    chk(sig ? "R10 wake wait" : "R9 wake wait", c, expw);
    chk("R12 ready low while waiting", bad, 0);
    chk(sig ? "R10 bits" : "R9 bits", last_bits, sig ? 32 + 8 : 8);
    chk("R9 opcode", last_hdr[0], 8'hAB);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int base, lows, vals, bsy;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 sck in reset", sck, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n after reset", cs_n, 1);
    chk("R12 ready after reset", cmd_ready, 1);

    run_read("R2 plain", 1'b0, 24'h012345, 5, 0);
    run_read("R3 fast stalled", 1'b1, 24'h0ABCDE, 4, 70);
    run_read("R7 wrap plain", 1'b0, 24'h0FFFFE, 4, 20);
    run_read("R7 wrap fast", 1'b1, 24'h0FFFFF, 3, 50);
    run_read("R6 zero length", 1'b0, 24'h000100, 0, 0);

    // R8: power-down, then a read is dropped
    do_cmd(2'd2, 1'b0, 24'h0, 0);
    wait_idle();
    chk("R8 opcode", last_hdr[0], 8'hB9);
    chk("R8 bits", last_bits, 8);
    base = frames; lows = 0; vals = 0; bsy = 0;
    do_cmd(2'd0, 1'b0, 24'h000010, 3);
    repeat (40) begin
      @(negedge clk);
      if (!cs_n) lows++;
      if (out_valid) vals++;
      if (busy) bsy++;
    end
    chk("R8 no frame while asleep", frames - base, 0);
    chk("R8 cs_n stays high", lows, 0);
    chk("R8 no output", vals, 0);
    chk("R8 busy low", bsy, 0);

    run_wake(1'b1, WS);
    run_read("R11 read after wake", 1'b0, 24'h054321, 3, 10);
    do_cmd(2'd2, 1'b0, 24'h0, 0);
    wait_idle();
    run_wake(1'b0, WP);
    run_read("R11 fast after plain wake", 1'b1, 24'h000003, 2, 0);

    for (int it = 0; it < 12; it++) begin
      logic [23:0] a = 24'($urandom);
      if (it % 4 == 0) a = 24'h0FFFFA + 24'($urandom % 6);
      run_read("R2 random", 1'($urandom % 2), a, 1 + int'($urandom % 6), int'($urandom % 60));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule